// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block gathers up to thirty-two interrupt lines from I/O functions and turns each enabled interrupt into a single memory write to the processor. Every line goes through a synchroniser. A rising edge on a line is recorded in a pending vector whether the line is enabled or not. When the line's enable bit is also set, the edge is recorded in a request vector and a message is queued. A message goes out as one write whose target is the programmable message-address register with its five low bits cleared. The data word of that write is those five low bits.

Software reaches the block through a small register port with word-indexed registers and per-byte write lanes. Reading the pending register returns its value and clears it. Writing it also clears it. Clearing pending clears the request vector too, and this is how software acknowledges interrupts. A bus-error bit in the control register holds back new messages while it is set. A mask written with bits outside the implemented line set raises a one-cycle configuration-fault pulse, and the value is still stored.

Several edges in one cycle are all recorded. Their messages leave in ascending line order, one per accepted valid/ready handshake, and each message carries the index of its source line on a sideband.

Top module: `irq_msg_aggregator`

## Requirements
- R1: After reset, the request, mask, pending and control registers read zero. The message-address register reads the ADDRESS_RESET parameter, which defaults to 32'h0000_1003.
- R2: The register word is chosen by acc_addr[4:2]. Index 0 is request (read-only), 1 is mask, 2 is pending, 3 is control and 4 is message address. Write lane acc_be[k] covers data bits [8k+7:8k]; the big-endian byte at offset 0 travels on lane 3. Writes to the request register have no effect.
- R3: A rising edge on irq_in[i] sets pending bit i whatever the mask holds. A line held high yields one event only.
- R4: A read of pending returns the value it held before the access, and the register is zero afterwards. A write of any data to pending also clears it.
- R5: A request bit is set only by an edge on a line whose mask bit is 1. The request register clears whenever pending is cleared.
- R6: Each edge on an enabled line produces one message. Its msg_addr is the message-address register with bits [4:0] forced to 0. Its msg_data is that register's bits [4:0], zero-extended.
- R7: While control bit 8 is 1, edges set pending and request bits but queue no message. A read of control returns bit 8 only, with every other bit 0.
- R8: A mask write whose resulting value has a bit outside {5,7,8,9,13,14,16..21,26} and is not all-ones pulses mask_fault high for the one cycle after the write. The value is stored either way.
- R9: Messages from edges recorded together leave in ascending line order, and msg_src carries the line index. msg_valid, msg_addr, msg_data and msg_src hold steady until msg_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Asynchronous interrupt lines, one per source |
| acc_sel | input | 1 | Register access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte offset of the access |
| acc_be | input | 4 | Byte-lane write enables |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the cycle of the access |
| mask_fault | output | 1 | One-cycle pulse after a mask write with unimplemented bits |
| msg_valid | output | 1 | Message write offered |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Target address of the message write |
| msg_data | output | 32 | Data word of the message write |
| msg_src | output | 5 | Line index that caused the message |

## Verification
The hardest state to reach from the ports is a backlog of several queued messages from one cycle, waiting behind a stalled handshake. The bench gets there by holding msg_ready low and raising four lines in the same cycle. It then releases ready and checks the order of msg_src. A second hard case is the mask/pending interaction on every line. The bench covers it with a full sweep of all thirty-two lines under an all-ones mask and again under the implemented-line mask. For every line it computes the expected request bit and message count from the mask value.

// File: rtl/irqagg_pkg.sv
// Package: shared widths, register indices and line assignments for the
// interrupt message aggregator. Assumes a 32-bit register word.
package irqagg_pkg;
    localparam int REG_W    = 32;
    localparam int LANES    = REG_W / 8;
    localparam int WORD_IDX = 3;

    localparam logic [WORD_IDX-1:0] IX_REQ  = 3'd0;
    localparam logic [WORD_IDX-1:0] IX_MASK = 3'd1;
    localparam logic [WORD_IDX-1:0] IX_PEND = 3'd2;
    localparam logic [WORD_IDX-1:0] IX_CTRL = 3'd3;
    localparam logic [WORD_IDX-1:0] IX_ADDR = 3'd4;

    localparam int CTRL_BUSERR = 8;
    localparam int ALIGN_BITS  = 5;

    // Source line assignment
    localparam int LINE_SERIAL   = 5;
    localparam int LINE_PARALLEL = 7;
    localparam int LINE_NETWORK  = 8;
    localparam int LINE_SCSI     = 9;
    localparam int LINE_AUDIO    = 13;
    localparam int LINE_SELF     = 14;
    localparam int LINE_KBD_PTR  = 26;

    // Set of implemented lines: 5,7,8,9,13,14,16..21,26
    localparam logic [REG_W-1:0] LINES_IMPL = 32'h043F_63A0;

    // Merge write data into an old word under byte-lane enables
    function automatic logic [REG_W-1:0] lane_merge(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] new_v,
        input logic [LANES-1:0] be
    );
        logic [REG_W-1:0] r;
        r = old_v;
        for (int b = 0; b < LANES; b++) begin
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/irqagg_edge.sv
// Module: synchronises the interrupt lines and emits a one-cycle pulse per
// rising edge. Assumes inputs are asynchronous levels; SYNC_STAGES >= 2.
module irqagg_edge #(
    parameter int LINES       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_async,
    output logic [LINES-1:0] line_rise
);
    logic [LINES-1:0] sync_q [SYNC_STAGES];
    logic [LINES-1:0] last_q;

    // Synchroniser chain and previous-level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
            last_q <= '0;
        end else begin
            sync_q[0] <= lines_async;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising edge of the synchronised level
    always_comb line_rise = sync_q[SYNC_STAGES-1] & ~last_q;

    // A held level never yields two consecutive events on one line
    assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rise & $past(line_rise)) == '0);
endmodule

// File: rtl/irqagg_regs.sv
// Module: register file with request, mask, pending, control and message
// address words; decides which edges become messages. Assumes one-cycle
// accesses with combinational read data; side effects take place at the
// clock edge that ends the access.
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter logic [REG_W-1:0] ADDRESS_RESET = 32'h0000_1003
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_sel,
    input  logic                acc_we,
    input  logic [WORD_IDX-1:0] acc_word,
    input  logic [LANES-1:0]    acc_be,
    input  logic [REG_W-1:0]    acc_wdata,
    output logic [REG_W-1:0]    acc_rdata,
    input  logic [REG_W-1:0]    line_rise,
    output logic [REG_W-1:0]    deliver,
    output logic [REG_W-1:0]    target_reg,
    output logic                mask_fault
);
    logic [REG_W-1:0] req_q, mask_q, pend_q, addr_q;
    logic             buserr_q;
    logic             hit_pend, wr_mask, wr_ctrl, wr_addr;
    logic [REG_W-1:0] mask_new, ctrl_new, addr_new;
    logic             mask_bad;

    // Access decode
    always_comb begin
        hit_pend = acc_sel && (acc_word == IX_PEND);
        wr_mask  = acc_sel && acc_we && (acc_word == IX_MASK);
        wr_ctrl  = acc_sel && acc_we && (acc_word == IX_CTRL);
        wr_addr  = acc_sel && acc_we && (acc_word == IX_ADDR);
        mask_new = lane_merge(mask_q, acc_wdata, acc_be);
        ctrl_new = lane_merge({{(REG_W-CTRL_BUSERR-1){1'b0}}, buserr_q,
                               {CTRL_BUSERR{1'b0}}}, acc_wdata, acc_be);
        addr_new = lane_merge(addr_q, acc_wdata, acc_be);
        mask_bad = ((mask_new & ~LINES_IMPL) != '0) && (mask_new != '1);
    end

    // Read multiplexer
    always_comb begin
        unique case (acc_word)
            IX_REQ:  acc_rdata = req_q;
            IX_MASK: acc_rdata = mask_q;
            IX_PEND: acc_rdata = pend_q;
            IX_CTRL: acc_rdata = {{(REG_W-CTRL_BUSERR-1){1'b0}}, buserr_q,
                                  {CTRL_BUSERR{1'b0}}};
            IX_ADDR: acc_rdata = addr_q;
            default: acc_rdata = '0;
        endcase
    end

    // Edges on enabled lines, suppressed for messaging while bus error is set
    always_comb deliver = buserr_q ? '0 : (line_rise & mask_q);
    always_comb target_reg = addr_q;

    // Pending and request vectors: clear on any pending access, then set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            req_q  <= '0;
        end else begin
            pend_q <= (hit_pend ? '0 : pend_q) | line_rise;
            req_q  <= (hit_pend ? '0 : req_q) | (line_rise & mask_q);
        end
    end

    // Writable configuration registers and fault pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '0;
            buserr_q   <= 1'b0;
            addr_q     <= ADDRESS_RESET;
            mask_fault <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= mask_new;
            if (wr_ctrl) buserr_q <= ctrl_new[CTRL_BUSERR];
            if (wr_addr) addr_q <= addr_new;
            mask_fault <= wr_mask && mask_bad;
        end
    end

    // A pending access leaves only the edges of that cycle behind
    assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && acc_word == IX_PEND) |=> (pend_q == $past(line_rise)));

    // Request never holds a bit that pending lacks
    assert_req_in_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q & ~pend_q) == '0);

    // Newly set request bits were enabled in the mask
    assert_req_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q & ~$past(req_q)) & ~$past(mask_q)) == '0);
endmodule

// File: rtl/irqagg_sender.sv
// Module: holds one outstanding-message flag per line and offers messages
// lowest line first over a valid/ready write port. Assumes the target
// register is sampled when a message is loaded.
module irqagg_sender
    import irqagg_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  deliver,
    input  logic [REG_W-1:0]  target_reg,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [REG_W-1:0]  msg_addr,
    output logic [REG_W-1:0]  msg_data,
    output logic [LINE_W-1:0] msg_src
);
    logic [LINES-1:0]  queue_q;
    logic [LINE_W-1:0] pick;
    logic              found, load;
    logic [LINES-1:0]  take;

    // Lowest-numbered outstanding line
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!found && queue_q[i]) begin
                found = 1'b1;
                pick  = LINE_W'(i);
            end
        end
        load = found && (!msg_valid || msg_ready);
        take = load ? (LINES'(1) << pick) : '0;
    end

    // Outstanding flags: remove the loaded line, add new deliveries
    always_ff @(posedge clk) begin
        if (!rst_n) queue_q <= '0;
        else        queue_q <= (queue_q & ~take) | deliver;
    end

    // Output message register with handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            msg_src   <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_src   <= pick;
            msg_addr  <= {target_reg[REG_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            msg_data  <= {{(REG_W-ALIGN_BITS){1'b0}}, target_reg[ALIGN_BITS-1:0]};
        end else if (msg_valid && msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // An offered message stays unchanged until accepted
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr)
                                       && $stable(msg_data) && $stable(msg_src)));

    // Message is aligned and carries only the low address bits
    assert_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[ALIGN_BITS-1:0] == '0
                       && msg_data[REG_W-1:ALIGN_BITS] == '0));
endmodule

// File: rtl/irq_msg_aggregator.sv
// Module: top of the interrupt message aggregator. Connects the edge
// detector, register file and message sender. Assumes 32 lines, one per
// register bit.
module irq_msg_aggregator
    import irqagg_pkg::*;
#(
    parameter int               SYNC_STAGES   = 2,
    parameter logic [REG_W-1:0] ADDRESS_RESET = 32'h0000_1003,
    localparam int              LINE_W        = $clog2(REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  irq_in,
    input  logic              acc_sel,
    input  logic              acc_we,
    input  logic [4:0]        acc_addr,
    input  logic [LANES-1:0]  acc_be,
    input  logic [REG_W-1:0]  acc_wdata,
    output logic [REG_W-1:0]  acc_rdata,
    output logic              mask_fault,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [REG_W-1:0]  msg_addr,
    output logic [REG_W-1:0]  msg_data,
    output logic [LINE_W-1:0] msg_src
);
    logic [REG_W-1:0] rise, deliver, target_reg;

    irqagg_edge #(.LINES(REG_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lines_async(irq_in), .line_rise(rise)
    );

    irqagg_regs #(.ADDRESS_RESET(ADDRESS_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_we(acc_we),
        .acc_word(acc_addr[4:2]), .acc_be(acc_be), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .line_rise(rise), .deliver(deliver),
        .target_reg(target_reg), .mask_fault(mask_fault)
    );

    irqagg_sender #(.LINES(REG_W), .LINE_W(LINE_W)) u_send (
        .clk(clk), .rst_n(rst_n), .deliver(deliver), .target_reg(target_reg),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_src(msg_src)
    );
endmodule

// File: tb/sim_irq_msg_aggregator.sv
module sim_irq_msg_aggregator;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] irq_in = 0;
    logic        acc_sel = 0, acc_we = 0;
    logic [4:0]  acc_addr = 0;
    logic [3:0]  acc_be = 0;
    logic [31:0] acc_wdata = 0;
    logic [31:0] acc_rdata;
    logic        mask_fault;
    logic        msg_valid, msg_ready = 1;
    logic [31:0] msg_addr, msg_data;
    logic [4:0]  msg_src;

    int errors = 0, checks = 0, cycles = 0;
    int msg_cnt = 0;
    int srcs [0:15];
    logic [31:0] last_addr, last_data;
    logic        last_fault;
    logic [31:0] impl;

    always #4 clk = ~clk;

    irq_msg_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .acc_sel(acc_sel),
        .acc_we(acc_we), .acc_addr(acc_addr), .acc_be(acc_be),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .mask_fault(mask_fault),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_src(msg_src)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    // Message monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (msg_cnt < 16) srcs[msg_cnt] = int'(msg_src);
            last_addr = msg_addr;
            last_data = msg_data;
            msg_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_write(input int idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        acc_sel = 1; acc_we = 1; acc_addr = 5'(idx * 4); acc_be = be; acc_wdata = d;
        @(posedge clk); #1;
        last_fault = mask_fault;
        acc_sel = 0; acc_we = 0; acc_be = 0;
    endtask

    task automatic reg_read(input int idx, output logic [31:0] d);
        @(negedge clk);
        acc_sel = 1; acc_we = 0; acc_addr = 5'(idx * 4);
        #2 d = acc_rdata;
        @(posedge clk); #1;
        acc_sel = 0;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk); irq_in = v;
        repeat (4) @(negedge clk);
        irq_in = 0;
        repeat (8) @(negedge clk);
    endtask

    logic [31:0] rd;

    initial begin
        impl = 0;
        foreach (impl[b]) if (b == 5 || b == 7 || b == 8 || b == 9 || b == 13 ||
                              b == 14 || (b >= 16 && b <= 21) || b == 26) impl[b] = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset values
        reg_read(0, rd); check("R1 request", rd, 0);
        reg_read(1, rd); check("R1 mask", rd, 0);
        reg_read(2, rd); check("R1 pending", rd, 0);
        reg_read(3, rd); check("R1 control", rd, 0);
        reg_read(4, rd); check("R1 address", rd, 32'h0000_1003);
        check("R1 no message", msg_valid, 0);

        // R3 R4 R5 R6: sweep every line with all lines enabled
        reg_write(1, 32'hFFFF_FFFF, 4'hF);
        check("R8 all-ones no fault", last_fault, 0);
        for (int i = 0; i < 32; i++) begin
            msg_cnt = 0;
            pulse(32'h1 << i);
            reg_read(0, rd); check("R5 request set", rd, 32'h1 << i);
            reg_read(2, rd); check("R3 pending set", rd, 32'h1 << i);
            reg_read(2, rd); check("R4 read clears", rd, 0);
            reg_read(0, rd); check("R5 request cleared", rd, 0);
            check("R6 one message", msg_cnt, 1);
            check("R6 address", last_addr, 32'h0000_1000);
            check("R6 data", last_data, 32'h3);
            check("R9 source", srcs[0], i);
        end

        // R3 R5 R6 R8: sweep with the implemented-line mask
        reg_write(1, impl, 4'hF);
        check("R8 implemented mask no fault", last_fault, 0);
        for (int i = 0; i < 32; i++) begin
            msg_cnt = 0;
            pulse(32'h1 << i);
            reg_read(0, rd); check("R5 request by mask", rd, impl & (32'h1 << i));
            reg_read(2, rd); check("R3 pending unmasked", rd, 32'h1 << i);
            check("R6 message count", msg_cnt, int'(impl[i]));
        end
        reg_write(1, 32'h0000_0001, 4'hF);
        check("R8 fault on bit 0", last_fault, 1);
        reg_read(1, rd); check("R8 value stored", rd, 32'h0000_0001);
        reg_write(1, 32'hFF00_0000, 4'b1000);
        check("R8 fault lane 3", last_fault, 1);
        reg_read(1, rd); check("R2 lane 3 merge", rd, 32'hFF00_0001);

        // R4 write clears pending
        reg_write(1, 32'hFFFF_FFFF, 4'hF);
        pulse(32'h80);
        reg_write(2, 32'h1234_5678, 4'hF);
        reg_read(2, rd); check("R4 write clears", rd, 0);
        reg_read(0, rd); check("R5 cleared by write", rd, 0);

        // R2 request register ignores writes
        reg_write(0, 32'hFFFF_FFFF, 4'hF);
        reg_read(0, rd); check("R2 request read-only", rd, 0);

        // R7 bus-error suppression
        reg_write(3, 32'hFFFF_FFFF, 4'hF);
        reg_read(3, rd); check("R7 control bit 8 only", rd, 32'h0000_0100);
        msg_cnt = 0;
        pulse(32'h200);
        check("R7 no message", msg_cnt, 0);
        reg_read(0, rd); check("R7 request still set", rd, 32'h200);
        reg_read(2, rd); check("R7 pending still set", rd, 32'h200);
        reg_write(3, 32'h0, 4'hF);
        reg_read(3, rd); check("R7 control cleared", rd, 0);

        // R9 ordering under backpressure
        @(posedge clk); #1 msg_ready = 0;
        msg_cnt = 0;
        pulse(32'h0410_0220);
        check("R9 held while stalled", msg_valid, 1);
        check("R9 none accepted", msg_cnt, 0);
        @(posedge clk); #1 msg_ready = 1;
        repeat (10) @(negedge clk);
        check("R9 four messages", msg_cnt, 4);
        check("R9 first", srcs[0], 5);
        check("R9 second", srcs[1], 9);
        check("R9 third", srcs[2], 20);
        check("R9 fourth", srcs[3], 26);
        reg_read(2, rd);

        // R2 R6 byte-lane writes of the message address
        reg_write(4, 32'h0000_001F, 4'b0001);
        reg_read(4, rd); check("R2 lane 0 merge", rd, 32'h0000_101F);
        msg_cnt = 0;
        pulse(32'h20);
        check("R6 count after lane write", msg_cnt, 1);
        check("R6 aligned address", last_addr, 32'h0000_1000);
        check("R6 low-bit data", last_data, 32'h1F);
        reg_write(4, 32'hABCD_EF00, 4'b1000);
        reg_read(4, rd); check("R2 lane 3 address", rd, 32'hAB00_101F);
        pulse(32'h20);
        check("R6 high address", last_addr, 32'hAB00_1000);

        finish_run();
    end
endmodule